// File: doc/BRIEF.md
# FIFO Occupancy Threshold Interrupt Controller

This block keeps the interrupt state of a byte-oriented two-wire serial controller that has a transmit FIFO and a receive FIFO. The FIFO storage and the transaction sequencer live elsewhere. They give this block the two occupancy counts, a busy level and single-cycle event pulses for transfer done, stop seen and timeout. The block turns these inputs into pending flags, masks the flags with software enables and drives one registered, level-sensitive interrupt line.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational from the read address. Software can program a receive threshold and a transmit threshold, clear event flags by writing ones, and request a flush of either FIFO. It can also read status bits that come from the busy level and the receive occupancy.

The receive threshold flag uses an "at or above" test and the transmit threshold flag uses an "at or below" test. Both flags are evaluated again from live occupancy on every clock, so a write-one-to-clear on a threshold bit has no lasting effect while its condition holds.

Top module: `thr_irq_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After reset, every pending flag, every enable bit and both thresholds are zero, and `irq`, `rx_flush` and `tx_flush` are low.
- R2: A one-cycle pulse on `ev_done`, `ev_stop` or `ev_timeout` sets the pending bit at position 0, 6 or 9 of word 0 at the next edge. The bit then stays set until it is cleared.
- R3: Writing word 0 clears each event pending bit whose position holds a 1 in the written data. Positions that hold 0 are left unchanged. If an event pulse and its clear arrive in the same cycle, the bit ends up set.
- R4: Pending bit 4 of word 0 equals, one edge late, the test rx_count >= the receive threshold. The receive threshold is held in bits 11:8 of word 3 and reads back there. Writing a 1 to bit 4 of word 0 does not hold the bit low while the test is true.
- R5: Pending bit 5 of word 0 equals, one edge late, the test tx_count <= the transmit threshold. The transmit threshold is held in bits 11:8 of word 4 and reads back there.
- R6: Word 1 holds the enable bits at positions 0, 4, 5, 6 and 9. Its other bits read 0. `irq` is a register loaded each edge with the OR over those five positions of pending AND enable.
- R7: Writing a 1 to bit 7 of word 3 drives `rx_flush` high for exactly the following cycle. Bit 7 of word 4 does the same for `tx_flush`. Bit 7 of both words always reads 0.
- R8: In word 2, bits 0 and 5 follow `busy`, bit 1 is high when rx_count is zero, and all other bits read 0. In word 5, bits 11:8 show rx_count, saturated at 15, and all other bits read 0. Read addresses 6 and 7 return 0.
- R9: Bit 15 of word 0 accepts a write-one-to-clear. The write has no effect, and the bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word index |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read word index |
| rd_data | output | 16 | Combinational read data |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| busy | input | 1 | Sequencer is not idle |
| ev_done | input | 1 | Transfer-done event pulse |
| ev_stop | input | 1 | Stop-condition event pulse |
| ev_timeout | input | 1 | Timeout event pulse |
| irq | output | 1 | Registered level interrupt |
| rx_flush | output | 1 | One-cycle receive FIFO flush request |
| tx_flush | output | 1 | One-cycle transmit FIFO flush request |

## Verification
The bench builds the block with the default CNT_W of 5, so occupancy runs from 0 to 31. This range goes above the largest 4-bit threshold. It therefore covers a receive flag that stays set for any threshold and a transmit flag that stays clear above 15. It also covers the saturation of the count field in word 5. A phase of random traffic mixes event pulses with writes to every address, which reaches set-versus-clear collisions and threshold changes in the same cycle as a count change.

// File: rtl/thr_irq_pkg.sv
// Package: shared register indices and bit positions for the threshold
// interrupt controller. Assumes a 16-bit register port with word indexing.
package thr_irq_pkg;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int TH_W  = 4;

    localparam logic [AW-1:0] A_PEND  = 3'd0;
    localparam logic [AW-1:0] A_EN    = 3'd1;
    localparam logic [AW-1:0] A_STAT  = 3'd2;
    localparam logic [AW-1:0] A_RXC   = 3'd3;
    localparam logic [AW-1:0] A_TXC   = 3'd4;
    localparam logic [AW-1:0] A_RXCNT = 3'd5;

    localparam int B_DONE  = 0;
    localparam int B_RXT   = 4;
    localparam int B_TXT   = 5;
    localparam int B_STOP  = 6;
    localparam int B_FLUSH = 7;
    localparam int B_TO    = 9;
    localparam int TH_LSB  = 8;
    localparam int N_EV    = 3;

    localparam logic [DW-1:0] SRC_MASK = 16'h0271;

    // Maps an event index to its pending bit position.
    function automatic int ev_pos(input int idx);
        case (idx)
            0:       return B_DONE;
            1:       return B_STOP;
            default: return B_TO;
        endcase
    endfunction
endpackage

// File: rtl/w1c_event_flag.sv
// Module: one sticky event flag. An event pulse sets it. A clear strobe
// resets it. The set wins when both arrive together. Assumes a
// synchronous active-low reset.
module w1c_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Holds the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R2
    AST_EVT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R3
endmodule

// File: rtl/occ_threshold_flag.sv
// Module: a registered occupancy-versus-threshold comparison. AT_LEAST=1
// tests count >= threshold and AT_LEAST=0 tests count <= threshold.
// Assumes CNT_W >= TH_W.
module occ_threshold_flag #(
    parameter int CNT_W    = 5,
    parameter int TH_W     = 4,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [TH_W-1:0]  thr_i,
    output logic             flag_o
);
    localparam int PAD = CNT_W - TH_W;

    logic [CNT_W-1:0] thr_ext;
    logic             hit;

    // Widens the threshold to the count width.
    always_comb thr_ext = {{PAD{1'b0}}, thr_i};

    generate
        if (AT_LEAST) begin : g_ge
            // Tests whether occupancy is at or above the threshold.
            always_comb hit = (count_i >= thr_ext);
        end else begin : g_le
            // Tests whether occupancy is at or below the threshold.
            always_comb hit = (count_i <= thr_ext);
        end
    endgenerate

    // Registers the comparison result once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= hit;
    end
endmodule

// File: rtl/thr_irq_ctrl.sv
// Module: top level of the threshold interrupt controller. Holds the
// pending, enable and threshold registers, issues flush pulses, serves
// reads and registers the IRQ. Assumes the FIFO counts and event pulses
// come from the same clock domain.
module thr_irq_ctrl
    import thr_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [2:0]       rd_addr,
    output logic [15:0]      rd_data,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             busy,
    input  logic             ev_done,
    input  logic             ev_stop,
    input  logic             ev_timeout,
    output logic             irq,
    output logic             rx_flush,
    output logic             tx_flush
);
    localparam int                FULL     = (1 << TH_W) - 1;
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(FULL);

    logic [DW-1:0]   en_q;
    logic [TH_W-1:0] rx_th_q;
    logic [TH_W-1:0] tx_th_q;
    logic [N_EV-1:0] ev_in;
    logic [N_EV-1:0] ev_q;
    logic            rx_thr;
    logic            tx_thr;
    logic [DW-1:0]   pend_vec;
    logic            pend_wr;
    logic [TH_W-1:0] rx_cnt_fld;

    // Collects the event pulses in index order.
    always_comb begin
        ev_in   = {ev_timeout, ev_stop, ev_done};
        pend_wr = wr_en && (wr_addr == A_PEND);
    end

    generate
        for (genvar g = 0; g < N_EV; g++) begin : g_ev
            w1c_event_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (ev_in[g]),
                .clr_i  (pend_wr && wr_data[ev_pos(g)]),
                .flag_o (ev_q[g])
            );
        end
    endgenerate

    occ_threshold_flag #(.CNT_W(CNT_W), .TH_W(TH_W), .AT_LEAST(1'b1)) u_rx_thr (
        .clk(clk), .rst_n(rst_n), .count_i(rx_count), .thr_i(rx_th_q), .flag_o(rx_thr)
    );

    occ_threshold_flag #(.CNT_W(CNT_W), .TH_W(TH_W), .AT_LEAST(1'b0)) u_tx_thr (
        .clk(clk), .rst_n(rst_n), .count_i(tx_count), .thr_i(tx_th_q), .flag_o(tx_thr)
    );

    // Places each pending source at its bit position.
    always_comb begin
        pend_vec           = '0;
        pend_vec[B_DONE]   = ev_q[0];
        pend_vec[B_STOP]   = ev_q[1];
        pend_vec[B_TO]     = ev_q[2];
        pend_vec[B_RXT]    = rx_thr;
        pend_vec[B_TXT]    = tx_thr;
    end

    // Holds the software-written enables and thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            rx_th_q <= '0;
            tx_th_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EN)  en_q    <= wr_data & SRC_MASK;
            if (wr_addr == A_RXC) rx_th_q <= wr_data[TH_LSB +: TH_W];
            if (wr_addr == A_TXC) tx_th_q <= wr_data[TH_LSB +: TH_W];
        end
    end

    // Issues the one-cycle flush requests that follow a flush write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= wr_en && (wr_addr == A_RXC) && wr_data[B_FLUSH];
            tx_flush <= wr_en && (wr_addr == A_TXC) && wr_data[B_FLUSH];
        end
    end

    // Registers the masked OR of all pending sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend_vec & en_q);
    end

    // Saturates the receive count into the 4-bit report field.
    always_comb rx_cnt_fld = (rx_count > FULL_CNT) ? TH_W'(FULL) : rx_count[TH_W-1:0];

    // Selects the read data for the current read index.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_PEND:  rd_data = pend_vec;
            A_EN:    rd_data = en_q;
            A_STAT:  begin
                rd_data[0] = busy;
                rd_data[1] = (rx_count == '0);
                rd_data[5] = busy;
            end
            A_RXC:   rd_data[TH_LSB +: TH_W] = rx_th_q;
            A_TXC:   rd_data[TH_LSB +: TH_W] = tx_th_q;
            A_RXCNT: rd_data[TH_LSB +: TH_W] = rx_cnt_fld;
            default: rd_data = '0;
        endcase
    end

    AST_RX_THR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(CNT_W-TH_W){1'b0}}, rx_th_q} <= rx_count) |=> pend_vec[B_RXT]); // R4
    AST_TX_THR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count > {{(CNT_W-TH_W){1'b0}}, tx_th_q}) |=> !pend_vec[B_TXT]); // R5
    AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_vec & en_q)) |=> irq); // R6
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_vec & en_q)) |=> !irq); // R6
    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RXC && wr_data[B_FLUSH]) |=> rx_flush); // R7
    AST_TX_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_TXC && wr_data[B_FLUSH]) |=> !tx_flush); // R7
endmodule

// File: tb/thr_irq_ctrl_tb.sv
// Bench: a behavioural reference model, stepped at every rising edge and
// compared with the outputs at every falling edge.
module thr_irq_ctrl_tb;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [15:0]      rd_data;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] tx_count = '0;
    logic             busy = 1'b0;
    logic             ev_done = 1'b0, ev_stop = 1'b0, ev_timeout = 1'b0;
    logic             irq, rx_flush, tx_flush;

    thr_irq_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_count(rx_count), .tx_count(tx_count),
        .busy(busy), .ev_done(ev_done), .ev_stop(ev_stop), .ev_timeout(ev_timeout),
        .irq(irq), .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    always #5 clk = ~clk;

    int compared = 0, mismatched = 0, cycles = 0;
    bit started = 0, done_run = 0;

    // Reference state.
    bit m_done, m_stop, m_to, m_rxt, m_txt, m_irq, m_rxfl, m_txfl;
    int m_en, m_rxth, m_txth;

    function automatic int m_pend();
        return (m_done ? 1 : 0) | (m_rxt ? 16 : 0) | (m_txt ? 32 : 0)
             | (m_stop ? 64 : 0) | (m_to ? 512 : 0);
    endfunction

    function automatic int m_read(input int a);
        int rc;
        rc = (int'(rx_count) > 15) ? 15 : int'(rx_count);
        case (a)
            0: return m_pend();
            1: return m_en;
            2: return (busy ? 33 : 0) | ((rx_count == 0) ? 2 : 0);
            3: return m_rxth << 8;
            4: return m_txth << 8;
            5: return rc << 8;
            default: return 0;
        endcase
    endfunction

    // Steps the reference model on each rising edge.
    always @(posedge clk) begin
        int clr, pend;
        started = 1;
        cycles++;
        if (!rst_n) begin
            {m_done, m_stop, m_to, m_rxt, m_txt, m_irq, m_rxfl, m_txfl} = '0;
            m_en = 0; m_rxth = 0; m_txth = 0;
        end else begin
            pend   = m_pend();
            m_irq  = (pend & m_en) != 0;
            clr    = (wr_en && wr_addr == 0) ? int'(wr_data) : 0;
            m_done = ev_done    || (m_done && !clr[0]);
            m_stop = ev_stop    || (m_stop && !clr[6]);
            m_to   = ev_timeout || (m_to   && !clr[9]);
            m_rxt  = int'(rx_count) >= m_rxth;
            m_txt  = int'(tx_count) <= m_txth;
            m_rxfl = wr_en && wr_addr == 3 && wr_data[7];
            m_txfl = wr_en && wr_addr == 4 && wr_data[7];
            if (wr_en && wr_addr == 1) m_en   = int'(wr_data) & 'h0271;
            if (wr_en && wr_addr == 3) m_rxth = int'(wr_data[11:8]);
            if (wr_en && wr_addr == 4) m_txth = int'(wr_data[11:8]);
        end
        if (cycles > 20000 && !done_run) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic string pend_req(input int bitpos);
        if (!rst_n) return "R1";
        case (bitpos)
            0, 6, 9: return "R3";
            4:       return "R4";
            5:       return "R5";
            15:      return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Compares every observable output at each falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk(rst_n ? "R6" : "R1", int'(irq), int'(m_irq));
            chk(rst_n ? "R7" : "R1", int'(rx_flush), int'(m_rxfl));
            chk(rst_n ? "R7" : "R1", int'(tx_flush), int'(m_txfl));
            if (rd_addr == 0) begin
                for (int b = 0; b < 16; b++)
                    chk(pend_req(b), int'(rd_data[b]), (m_read(0) >> b) & 1);
            end else if (rd_addr == 1) chk(rst_n ? "R6" : "R1", int'(rd_data), m_read(1));
            else if (rd_addr == 3 || rd_addr == 4) chk(rst_n ? "R7" : "R1", int'(rd_data), m_read(int'(rd_addr)));
            else chk("R8", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        rd_addr = rd_addr + 3'd1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        tick();
        idle(9);                       // R1: reset state observed on every word
        rst_n = 1'b1;
        idle(8);
        wr(1, 16'hFFFF);               // R6: only five enable bits stick
        ev_done = 1; tick(); ev_done = 0; idle(8);    // R2
        ev_stop = 1; tick(); ev_stop = 0; idle(8);    // R2
        ev_timeout = 1; tick(); ev_timeout = 0; idle(8);
        wr(0, 16'h0001); idle(8);      // R3: clear done only
        wr(0, 16'h0000); idle(8);      // R3: zeros leave flags alone
        ev_stop = 1; wr(0, 16'h0040); ev_stop = 0; idle(8); // R3: set wins
        wr(0, 16'h8000); idle(8);      // R9: no effect
        wr(0, 16'h0271); idle(8);
        wr(3, 16'h0500);               // R4: threshold 5
        for (int c = 0; c < 32; c++) begin rx_count = CNT_W'(c); idle(2); end
        wr(0, 16'h0030); idle(8);      // R4: W1C while condition holds
        wr(4, 16'h0300);               // R5: threshold 3
        for (int c = 31; c >= 0; c--) begin tx_count = CNT_W'(c); idle(2); end
        wr(1, 16'h0020);               // R6: transmit threshold only
        tx_count = 2; idle(8); tx_count = 9; idle(8);
        wr(1, 16'h0000); idle(8);
        wr(3, 16'h0F80); wr(4, 16'h0080); wr(3, 16'h0080); idle(8); // R7
        busy = 1; rx_count = 0; idle(8);                            // R8
        rx_count = 20; idle(8); busy = 0; rx_count = 15; idle(8);
        for (int i = 0; i < 600; i++) begin  // mixed traffic
            ev_done    = ($urandom % 7) == 0;
            ev_stop    = ($urandom % 9) == 0;
            ev_timeout = ($urandom % 11) == 0;
            rx_count   = CNT_W'($urandom);
            tx_count   = CNT_W'($urandom);
            busy       = $urandom % 2 == 1;
            if ($urandom % 3 == 0) wr(3'($urandom % 6), 16'($urandom));
            else tick();
        end
        ev_done = 0; ev_stop = 0; ev_timeout = 0;
        idle(8);
        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule